// File: doc/BRIEF.md
# Predicate Register File and Retire Gate

This block keeps a bank of one-bit predicate registers and decides, at the moment an instruction retires, whether its result may reach the architectural register file. Every instruction flows down the pipeline and executes regardless of its predicate. Only at retirement is the predicate named by the instruction looked up. A false predicate turns the writeback into a no-op.

Compare operations load predicates in complementary pairs. In one cycle, the first named predicate takes the compare outcome and the second takes its inverse, so the two arms of an if/else can be issued as one straight stream. Retiring instructions may also be conditional moves: a move-if-zero or a move-if-nonzero inspects a test operand. It only writes when both the test and the predicate allow it.

The register-file write port is registered and updates on the clock edge that follows the retire request. Predicate slot 0 always reads true, so unconditional code names index 0.

Top module: `pred_retire_gate`

## Requirements
- R1: After reset, predicate slots 1 through 63 read false, `rf_we` is 0, and `rf_waddr`/`rf_wdata` are 0.
- R2: Predicate slot 0 always reads true, and compare writes aimed at it leave it unchanged.
- R3: A compare with `cmp_valid`=1 and distinct targets sets slot `cmp_dst_t` to `cmp_result` and slot `cmp_dst_f` to its inverse, both on the same clock edge.
- R4: When `cmp_valid`=1 and `cmp_dst_t` equals `cmp_dst_f`, `cmp_illegal` is 1 in that same cycle and no predicate changes. Otherwise `cmp_illegal` is 0.
- R5: A retire in the cycle right after a compare sees the new predicate values. A retire in the same cycle as the compare sees the old values.
- R6: A retire with `ret_valid`=1, kind 0 (plain) and a true predicate drives `rf_we`=1, `rf_waddr`=`ret_dst` and `rf_wdata`=`ret_data` one clock after the request.
- R7: When the named predicate is false, no write occurs, and `rf_waddr`/`rf_wdata` keep their previous values.
- R8: Kind 1 (move if zero) writes only if `ret_test` equals 0 and the predicate is true.
- R9: Kind 2 (move if nonzero) writes only if `ret_test` is not 0 and the predicate is true.
- R10: Kind 3 is reserved and never writes.
- R11: With `ret_valid`=0, no write occurs, whatever the other retire inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare result present this cycle |
| cmp_result | input | 1 | Compare outcome (1 = condition true) |
| cmp_dst_t | input | 6 | Predicate receiving the outcome |
| cmp_dst_f | input | 6 | Predicate receiving the inverted outcome |
| cmp_illegal | output | 1 | Both compare targets are the same slot |
| ret_valid | input | 1 | Instruction retiring this cycle |
| ret_kind | input | 2 | 0 plain, 1 move-if-zero, 2 move-if-nonzero, 3 reserved |
| ret_pidx | input | 6 | Guarding predicate index |
| ret_dst | input | 5 | Destination register |
| ret_data | input | 32 | Result data |
| ret_test | input | 32 | Test operand for conditional moves |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |

## Verification
The bound checker checks the following properties on every cycle:
- slot 0 stays true;
- the outcome of a legal compare lands in the named slot;
- an illegal compare freezes the bank;
- invalid, reserved or test-failing retires never raise the write enable;
- the write address and data hold whenever no write happens.

Some behaviours only the bench scenarios can show, because they need a reference model of the whole bank. These are:
- the exact pairing of complementary values across later retires;
- the same-cycle versus next-cycle visibility of a compare;
- the overwriting of a pair by a later compare with the opposite outcome.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {
    RK_PLAIN  = 2'd0,
    RK_MOVZ   = 2'd1,
    RK_MOVNZ  = 2'd2,
    RK_RSVD   = 2'd3
  } ret_kind_e;
endpackage

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int NUM_PRED = 64,
  localparam int IW = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_res,
  input  logic [IW-1:0]       wr_idx_t,
  input  logic [IW-1:0]       wr_idx_f,
  input  logic [IW-1:0]       rd_idx,
  output logic                rd_val,
  output logic [NUM_PRED-1:0] bank_q
);
  // Slot 0 is a constant true.
  assign bank_q[0] = 1'b1;

  for (genvar i = 1; i < NUM_PRED; i++) begin : g_slot
    logic hit_t, hit_f, en, d;
    always_comb begin
      hit_t = (wr_idx_t == IW'(i));
      hit_f = (wr_idx_f == IW'(i));
      en    = wr_en && (hit_t || hit_f);
      d     = hit_t ? wr_res : ~wr_res;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[i] <= 1'b0;
      end else if (en) begin
        bank_q[i] <= d;
      end
    end
  end

  assign rd_val = bank_q[rd_idx];
endmodule

// File: rtl/cmov_eval.sv
module cmov_eval #(
  parameter int DATA_W = 32
) (
  input  pred_pkg::ret_kind_e kind,
  input  logic [DATA_W-1:0]   test,
  output logic                allow
);
  import pred_pkg::*;
  logic is_zero;
  always_comb begin
    is_zero = (test == '0);
    unique case (kind)
      RK_PLAIN: allow = 1'b1;
      RK_MOVZ:  allow = is_zero;
      RK_MOVNZ: allow = !is_zero;
      default:  allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/wb_stage.sv
module wb_stage #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [REG_AW-1:0] dst,
  input  logic [DATA_W-1:0] data,
  output logic              we_q,
  output logic [REG_AW-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  logic              we_d;
  logic [REG_AW-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    we_d   = fire;
    addr_d = fire ? dst  : addr_q;
    data_d = fire ? data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b0;
    end else begin
      we_q <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/pred_retire_gate.sv
module pred_retire_gate #(
  parameter int NUM_PRED = 64,
  parameter int REG_AW   = 5,
  parameter int DATA_W   = 32,
  localparam int PIDX_W  = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              cmp_result,
  input  logic [PIDX_W-1:0] cmp_dst_t,
  input  logic [PIDX_W-1:0] cmp_dst_f,
  output logic              cmp_illegal,
  input  logic              ret_valid,
  input  logic [1:0]        ret_kind,
  input  logic [PIDX_W-1:0] ret_pidx,
  input  logic [REG_AW-1:0] ret_dst,
  input  logic [DATA_W-1:0] ret_data,
  input  logic [DATA_W-1:0] ret_test,
  output logic              rf_we,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  import pred_pkg::*;

  logic                same_tgt;
  logic                pair_wr;
  logic                pred_hit;
  logic                cond_ok;
  logic                fire;
  logic [NUM_PRED-1:0] pred_vec;
  ret_kind_e           kind;

  always_comb begin
    same_tgt    = (cmp_dst_t == cmp_dst_f);
    cmp_illegal = cmp_valid && same_tgt;
    pair_wr     = cmp_valid && !same_tgt;
    kind        = ret_kind_e'(ret_kind);
  end

  pred_bank #(.NUM_PRED(NUM_PRED)) i_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pair_wr),
    .wr_res   (cmp_result),
    .wr_idx_t (cmp_dst_t),
    .wr_idx_f (cmp_dst_f),
    .rd_idx   (ret_pidx),
    .rd_val   (pred_hit),
    .bank_q   (pred_vec)
  );

  cmov_eval #(.DATA_W(DATA_W)) i_cond (
    .kind  (kind),
    .test  (ret_test),
    .allow (cond_ok)
  );

  always_comb fire = ret_valid && pred_hit && cond_ok;

  wb_stage #(.REG_AW(REG_AW), .DATA_W(DATA_W)) i_wb (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .dst    (ret_dst),
    .data   (ret_data),
    .we_q   (rf_we),
    .addr_q (rf_waddr),
    .data_q (rf_wdata)
  );
endmodule

// File: rtl/pred_retire_gate_chk.sv
module pred_retire_gate_chk #(
  parameter int NUM_PRED = 64,
  parameter int REG_AW   = 5,
  parameter int DATA_W   = 32,
  localparam int PIDX_W  = $clog2(NUM_PRED)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmp_valid,
  input logic                cmp_result,
  input logic [PIDX_W-1:0]   cmp_dst_t,
  input logic [PIDX_W-1:0]   cmp_dst_f,
  input logic                cmp_illegal,
  input logic                ret_valid,
  input logic [1:0]          ret_kind,
  input logic [DATA_W-1:0]   ret_test,
  input logic                rf_we,
  input logic [REG_AW-1:0]   rf_waddr,
  input logic [DATA_W-1:0]   rf_wdata,
  input logic [NUM_PRED-1:0] pred_vec
);
  // R2
  slot0_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vec[0]);

  // R3
  cmp_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_illegal && cmp_dst_t != '0) |=>
      (pred_vec[$past(cmp_dst_t)] == $past(cmp_result)));

  // R4
  illegal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_illegal |=> (pred_vec == $past(pred_vec)));

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_we |-> ($stable(rf_waddr) && $stable(rf_wdata)));

  // R8
  movz_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind == 2'd1 && ret_test != '0) |=> !rf_we);

  // R9
  movnz_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind == 2'd2 && ret_test == '0) |=> !rf_we);

  // R10
  rsvd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind == 2'd3) |=> !rf_we);

  // R11
  no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !rf_we);
endmodule

bind pred_retire_gate pred_retire_gate_chk #(
  .NUM_PRED(NUM_PRED), .REG_AW(REG_AW), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
  .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f), .cmp_illegal(cmp_illegal),
  .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_test(ret_test),
  .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pred_vec(pred_vec)
);

// File: tb/test_pred_retire_gate.sv
module test_pred_retire_gate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid, cmp_result;
  logic [5:0]  cmp_dst_t, cmp_dst_f;
  logic        cmp_illegal;
  logic        ret_valid;
  logic [1:0]  ret_kind;
  logic [5:0]  ret_pidx;
  logic [4:0]  ret_dst;
  logic [31:0] ret_data, ret_test;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  bit          model[64];
  logic [4:0]  last_addr;
  logic [31:0] last_data;

  always #10 clk = ~clk;

  pred_retire_gate i_pred_retire_gate (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
    .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f), .cmp_illegal(cmp_illegal),
    .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_pidx(ret_pidx),
    .ret_dst(ret_dst), .ret_data(ret_data), .ret_test(ret_test),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Drive one cycle of stimulus at the falling edge and queue the expectation.
  task automatic step(input bit cv, input bit cres, input int ct, input int cf,
                      input bit rv, input int kind, input int pidx, input int dst,
                      input logic [31:0] data, input logic [31:0] test,
                      input string req);
    exp_t e;
    bit   pr, ok, ill;
    @(negedge clk);
    pr = model[pidx];
    case (kind)
      0: ok = 1'b1;
      1: ok = (test == 32'd0);
      2: ok = (test != 32'd0);
      default: ok = 1'b0;
    endcase
    e.we = rv && pr && ok;
    if (e.we) begin
      last_addr = dst[4:0];
      last_data = data;
    end
    e.addr = last_addr;
    e.data = last_data;
    e.req  = req;
    exp_q.push_back(e);
    ill = cv && (ct == cf);
    if (cv && !ill) begin
      if (ct != 0) model[ct] = cres;
      if (cf != 0) model[cf] = !cres;
    end
    cmp_valid = cv; cmp_result = cres;
    cmp_dst_t = ct[5:0]; cmp_dst_f = cf[5:0];
    ret_valid = rv; ret_kind = kind[1:0]; ret_pidx = pidx[5:0];
    ret_dst = dst[4:0]; ret_data = data; ret_test = test;
    #1;
    check(cmp_illegal == ill, "R4",
          $sformatf("cmp_illegal act=%0b exp=%0b", cmp_illegal, ill));
  endtask

  // Monitor: compares the registered write port just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(rf_we == e.we && rf_waddr == e.addr && rf_wdata == e.data, e.req,
              $sformatf("we/addr/data act=%0b/%0d/%h exp=%0b/%0d/%h",
                        rf_we, rf_waddr, rf_wdata, e.we, e.addr, e.data));
      end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    last_addr = '0; last_data = '0;
    rst_n = 1'b0;
    cmp_valid = 0; cmp_result = 0; cmp_dst_t = 0; cmp_dst_f = 0;
    ret_valid = 0; ret_kind = 0; ret_pidx = 0; ret_dst = 0;
    ret_data = 0; ret_test = 0;
    repeat (3) @(posedge clk);
    #2;
    check(rf_we == 0 && rf_waddr == 0 && rf_wdata == 0, "R1",
          $sformatf("reset we/addr/data act=%0b/%0d/%h exp=0/0/0",
                    rf_we, rf_waddr, rf_wdata));
    @(negedge clk);
    rst_n = 1'b1;

    // R1: slots start false
    step(0,0,0,0, 1,0,5,3, 32'h11,0, "R1");
    step(0,0,0,0, 1,0,63,3, 32'h12,0, "R1");
    // R6 / R2: slot 0 unconditional
    step(0,0,0,0, 1,0,0,7, 32'hA5A5_0001,0, "R6");
    // R2: compare aiming at slot 0 with false outcome
    step(1,0,0,7, 0,0,0,0, 0,0, "R11");
    step(0,0,0,0, 1,0,0,9, 32'h22,0, "R2");
    step(0,0,0,0, 1,0,7,10, 32'h23,0, "R3");
    // R3 / R5: pair write, next-cycle visibility
    step(1,1,3,4, 0,0,0,0, 0,0, "R11");
    step(0,0,0,0, 1,0,3,11, 32'h33,0, "R5");
    step(0,0,0,0, 1,0,4,12, 32'h34,0, "R7");
    // R5: same-cycle retire sees the old value
    step(1,1,9,10, 1,0,9,13, 32'h44,0, "R5");
    step(0,0,0,0, 1,0,9,14, 32'h45,0, "R5");
    step(0,0,0,0, 1,0,10,15, 32'h46,0, "R3");
    // R3: opposite outcome overwrites the pair
    step(1,0,3,4, 0,0,0,0, 0,0, "R11");
    step(0,0,0,0, 1,0,4,16, 32'h55,0, "R3");
    step(0,0,0,0, 1,0,3,17, 32'h56,0, "R7");
    // R4: same target is illegal and leaves slot unchanged
    step(1,1,12,12, 0,0,0,0, 0,0, "R4");
    step(0,0,0,0, 1,0,12,18, 32'h66,0, "R4");
    step(1,1,12,13, 0,0,0,0, 0,0, "R11");
    step(1,0,12,12, 0,0,0,0, 0,0, "R4");
    step(0,0,0,0, 1,0,12,19, 32'h67,0, "R4");
    // R8: move if zero
    step(0,0,0,0, 1,1,0,20, 32'h77,32'd0, "R8");
    step(0,0,0,0, 1,1,0,21, 32'h78,32'd5, "R8");
    step(0,0,0,0, 1,1,13,22, 32'h79,32'd0, "R8");
    // R9: move if nonzero
    step(0,0,0,0, 1,2,0,23, 32'h88,32'hFFFF_FFFF, "R9");
    step(0,0,0,0, 1,2,0,24, 32'h89,32'd0, "R9");
    step(0,0,0,0, 1,2,13,25, 32'h8A,32'd1, "R9");
    // R10: reserved kind
    step(0,0,0,0, 1,3,0,26, 32'h99,32'd0, "R10");
    // R11: valid low
    step(0,0,0,0, 0,0,0,27, 32'hAA,0, "R11");
    step(0,0,0,0, 0,0,0,0, 0,0, "R11");
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule